// File: doc/BRIEF.md
# Secondary Core Release Mailbox

This block holds the secondary processor cores of a small cluster in a parked state until software running on the primary core hands each of them a start address. It is a region of word-wide storage on a simple register bus. A fixed word in that region serves as each core's slot. One 32-bit value does two jobs: zero means "keep waiting", and any nonzero value is both the go signal and the branch target.

Any bus write that lands on the slot of a present core raises a one-cycle wake event, which models the event that rouses sleeping cores. On the cycle after a wake, every secondary core that is still parked looks at its slot. A core whose slot is nonzero gets a one-cycle release pulse that carries the slot value as its jump target. After that the core counts as running and ignores its slot until the next reset. Core 0 is the primary core. It is never parked and never released, but its slot is ordinary storage like every other word.

Top module: `core_release_mbx`

## Requirements
- R1: The slot of core N (N = 0 to NUM_CORES-1) is the word at byte offset 0x40 + 0x10*N. The core number is taken from a 4-bit field, offset bits [7:4] minus 4, and the slot is selected only when offset bits [3:2] are zero.
- R2: A synchronous active-low reset clears every stored word to zero, parks cores 1 to NUM_CORES-1, and drives all release pulses and the wake output low.
- R3: A write to the slot of a present core (core 0 included) makes `wake_evt` high for exactly the one cycle after the write. A write to any other offset, including the slot position of a core that is not present, raises no wake.
- R4: In the cycle after `wake_evt` is high, each parked secondary core whose slot is nonzero gets `rel_valid[N]` high for one cycle, with `rel_target` bits [32N+31:32N] equal to the slot value.
- R5: A wake that finds a parked core's slot at zero leaves the core parked. A later nonzero write to that slot then releases it.
- R6: Once a core has been released, further writes to its slot are stored but produce no release pulse until the next reset. After a reset the core can be released again.
- R7: A write to core 0's slot is stored and raises the wake, but `rel_valid[0]` stays low at all times.
- R8: Every word of the region is writable, and it reads back one cycle after a read strobe. Offset bits [1:0] are ignored, so all accesses are whole 32-bit words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset within the mailbox region |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after `bus_rd` |
| rel_valid | output | NUM_CORES | Per-core one-cycle release pulse (bit 0 always low) |
| rel_target | output | NUM_CORES*DATA_W | Per-core jump address, core N in bits [32N+31:32N] |
| wake_evt | output | 1 | One-cycle wake event after a slot write |

## Verification
The bench builds two copies side by side on one shared bus: the default four-core mailbox and a two-core one, both with an 8-bit offset and 32-bit data. The four-core copy brings every slot position into play, including the highest core. The two-core copy turns the slot offsets of cores 2 and 3 into plain storage, so the same write both wakes and does not wake. Periodic resets inside the random phase let each core be released more than once across the run.

// File: rtl/mbx_pkg.sv
// Package: constants and types shared by the mailbox blocks.
// Assumes byte offsets on the bus and 32-bit words.
package mbx_pkg;
    // Slot table placement: core N at SLOT_BASE + N * SLOT_STRIDE (bytes)
    localparam int unsigned SLOT_BASE_BYTE   = 32'h40;
    localparam int unsigned SLOT_STRIDE_BYTE = 32'h10;
    // Derived word indices
    localparam int unsigned SLOT_BASE_WORD   = SLOT_BASE_BYTE / 4;
    localparam int unsigned SLOT_STRIDE_WORD = SLOT_STRIDE_BYTE / 4;
    // Core field position inside the offset
    localparam int unsigned CORE_FIELD_LSB   = 4;
    localparam int unsigned CORE_FIELD_W     = 4;
    localparam int unsigned MAX_CORES        = 4;

    // Result of decoding one bus offset
    typedef struct packed {
        logic                    hit;
        logic [CORE_FIELD_W-1:0] core;
    } slot_sel_t;

    // Per-core gate state
    typedef enum logic {
        GATE_PARKED  = 1'b0,
        GATE_RUNNING = 1'b1
    } gate_state_e;
endpackage

// File: rtl/mbx_slot_decode.sv
// Module: mbx_slot_decode
// Maps a word offset to "is this a present core's slot, and which core".
// Assumes ADDR_W >= 8 and that the caller has dropped offset bits [1:0].
module mbx_slot_decode
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned NUM_CORES = 4
) (
    input  logic [ADDR_W-1:2] word_addr,
    output slot_sel_t         sel
);
    localparam int unsigned FIELD_MSB = CORE_FIELD_LSB + CORE_FIELD_W - 1;
    localparam logic [CORE_FIELD_W-1:0] BASE_FIELD = CORE_FIELD_W'(SLOT_BASE_BYTE >> CORE_FIELD_LSB);
    localparam logic [CORE_FIELD_W-1:0] NC_FIELD   = CORE_FIELD_W'(NUM_CORES);

    logic                    upper_zero;
    logic [CORE_FIELD_W-1:0] field;
    logic [CORE_FIELD_W-1:0] core_num;

    // Offsets above the core field must be zero for a slot hit
    generate
        if (ADDR_W > FIELD_MSB + 1) begin : g_upper
            assign upper_zero = ~|word_addr[ADDR_W-1:FIELD_MSB+1];
        end else begin : g_no_upper
            assign upper_zero = 1'b1;
        end
    endgenerate

    assign field    = word_addr[FIELD_MSB:CORE_FIELD_LSB];
    assign core_num = field - BASE_FIELD;

    // Slot hit: word aligned to the stride, inside the present-core range
    always_comb begin
        sel.core = core_num;
        sel.hit  = upper_zero
                 && (word_addr[CORE_FIELD_LSB-1:2] == '0)
                 && (field >= BASE_FIELD)
                 && (core_num < NC_FIELD);
    end
endmodule

// File: rtl/mbx_word_store.sv
// Module: mbx_word_store
// Word-wide storage covering the whole mailbox region, with a registered
// read port and a parallel view of the secondary cores' slot words.
// Assumes at most one write per cycle; a read in the same cycle as a
// write returns the old word.
module mbx_word_store
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned NUM_CORES = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-3:0]                 wr_idx,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic                              rd_en,
    input  logic [ADDR_W-3:0]                 rd_idx,
    output logic [DATA_W-1:0]                 rd_data,
    output logic [(NUM_CORES-1)*DATA_W-1:0]   sec_slots
);
    localparam int unsigned WORDS = 1 << (ADDR_W - 2);

    logic [DATA_W-1:0] words [WORDS];

    // Storage: cleared on reset, one word written per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < WORDS; k++) begin
                words[k] <= '0;
            end
        end else if (wr_en) begin
            words[wr_idx] <= wr_data;
        end
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= words[rd_idx];
        end
    end

    // Parallel slot view for cores 1 .. NUM_CORES-1
    generate
        for (genvar n = 1; n < NUM_CORES; n++) begin : g_slot
            localparam int unsigned IDX = SLOT_BASE_WORD + n * SLOT_STRIDE_WORD;
            assign sec_slots[(n-1)*DATA_W +: DATA_W] = words[IDX];
        end
    endgenerate
endmodule

// File: rtl/mbx_core_gate.sv
// Module: mbx_core_gate
// Holds one secondary core parked. On a wake it checks the core's slot
// and, if nonzero, issues a single release pulse with that target.
// Assumes wake is a one-cycle pulse and slot reflects the stored word.
module mbx_core_gate
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wake,
    input  logic [DATA_W-1:0] slot,
    output logic              rel_valid,
    output logic [DATA_W-1:0] rel_target
);
    gate_state_e state;

    // Park / release state and registered release outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= GATE_PARKED;
            rel_valid  <= 1'b0;
            rel_target <= '0;
        end else begin
            rel_valid <= 1'b0;
            if (state == GATE_PARKED && wake && (slot != '0)) begin
                state      <= GATE_RUNNING;
                rel_valid  <= 1'b1;
                rel_target <= slot;
            end
        end
    end
endmodule

// File: rtl/core_release_mbx.sv
// Module: core_release_mbx
// Mailbox that releases parked secondary cores. Software writes a jump
// address into a core's slot; a write to any present slot raises a
// one-cycle wake; parked cores with a nonzero slot then get a release.
// Assumes 2 <= NUM_CORES <= 4, ADDR_W >= 8, whole-word accesses only.
module core_release_mbx
    import mbx_pkg::*;
#(
    parameter int unsigned NUM_CORES = 4,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    output logic [NUM_CORES-1:0]          rel_valid,
    output logic [NUM_CORES*DATA_W-1:0]   rel_target,
    output logic                          wake_evt
);
    slot_sel_t                           sel;
    logic [(NUM_CORES-1)*DATA_W-1:0]     sec_slots;
    logic [1:0]                          unused_byte_lanes;

    assign unused_byte_lanes = bus_addr[1:0];

    mbx_slot_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_CORES (NUM_CORES)
    ) u_decode (
        .word_addr (bus_addr[ADDR_W-1:2]),
        .sel       (sel)
    );

    mbx_word_store #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .NUM_CORES (NUM_CORES)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .wr_idx    (bus_addr[ADDR_W-1:2]),
        .wr_data   (bus_wdata),
        .rd_en     (bus_rd),
        .rd_idx    (bus_addr[ADDR_W-1:2]),
        .rd_data   (bus_rdata),
        .sec_slots (sec_slots)
    );

    // Wake event: one cycle after any write to a present core's slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_evt <= 1'b0;
        end else begin
            wake_evt <= bus_wr && sel.hit;
        end
    end

    // Core 0 is the primary core and is never released
    assign rel_valid[0]           = 1'b0;
    assign rel_target[DATA_W-1:0] = '0;

    generate
        for (genvar n = 1; n < NUM_CORES; n++) begin : g_gate
            mbx_core_gate #(
                .DATA_W (DATA_W)
            ) u_gate (
                .clk        (clk),
                .rst_n      (rst_n),
                .wake       (wake_evt),
                .slot       (sec_slots[(n-1)*DATA_W +: DATA_W]),
                .rel_valid  (rel_valid[n]),
                .rel_target (rel_target[n*DATA_W +: DATA_W])
            );
        end
    endgenerate
endmodule

// File: rtl/core_release_mbx_chk.sv
// Module: core_release_mbx_chk
// Assertion checker bound to core_release_mbx. Observes only ports.
module core_release_mbx_chk #(
    parameter int unsigned NUM_CORES = 4,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_wr,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [NUM_CORES-1:0]        rel_valid,
    input logic [NUM_CORES*DATA_W-1:0] rel_target,
    input logic                        wake_evt
);
    logic                 slot_wr;
    logic [NUM_CORES-1:0] fired;
    int unsigned          slot_no;

    // Independent view of "this write targets a present core's slot"
    always_comb begin
        slot_no = int'(bus_addr[7:4]) - 4;
        slot_wr = bus_wr && (bus_addr[3:2] == 2'b00) && (bus_addr[7:4] >= 4'd4)
                  && (slot_no < NUM_CORES)
                  && ((ADDR_W <= 8) || ((bus_addr >> 8) == '0));
    end

    // Record cores that have already been released since reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fired <= '0;
        end else begin
            fired <= fired | rel_valid;
        end
    end

    // R3: a slot write raises the wake in the next cycle
    a_r3_wake_after_slot_write: assert property (@(posedge clk) disable iff (!rst_n)
        slot_wr |=> wake_evt);

    // R3: no wake without a slot write in the cycle before
    a_r3_no_spurious_wake: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_wr |=> !wake_evt);

    // R7: the primary core is never released
    a_r7_primary_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_valid[0]);

    generate
        for (genvar n = 1; n < NUM_CORES; n++) begin : g_core
            // R4: a release only follows a wake
            a_r4_release_after_wake: assert property (@(posedge clk) disable iff (!rst_n)
                rel_valid[n] |-> $past(wake_evt));

            // R4: a release carries a nonzero target
            a_r4_target_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
                rel_valid[n] |-> (rel_target[n*DATA_W +: DATA_W] != '0));

            // R6: at most one release per core between resets
            a_r6_single_release: assert property (@(posedge clk) disable iff (!rst_n)
                fired[n] |-> !rel_valid[n]);
        end
    endgenerate
endmodule

bind core_release_mbx core_release_mbx_chk #(
    .NUM_CORES (NUM_CORES),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .rel_valid  (rel_valid),
    .rel_target (rel_target),
    .wake_evt   (wake_evt)
);

// File: tb/core_release_mbx_bench.sv
`timescale 1ns/1ps
// Bench: a four-core and a two-core mailbox on one shared bus, checked
// against a bench-side model of storage, wake and park state.
module core_release_mbx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;

    logic [31:0]  rdata4, rdata2;
    logic [3:0]   rv4;
    logic [127:0] rt4;
    logic         wake4;
    logic [1:0]   rv2;
    logic [63:0]  rt2;
    logic         wake2;

    always #2.5 clk = ~clk;

    core_release_mbx #(.NUM_CORES(4), .ADDR_W(8), .DATA_W(32)) u_core_release_mbx (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata4), .rel_valid(rv4),
        .rel_target(rt4), .wake_evt(wake4));

    core_release_mbx #(.NUM_CORES(2), .ADDR_W(8), .DATA_W(32)) u_core_release_mbx_two (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata2), .rel_valid(rv2),
        .rel_target(rt2), .wake_evt(wake2));

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] mem [2][64];
    bit          parked [2][4];

    function automatic int nc_of(int i);
        return (i == 0) ? 4 : 2;
    endfunction

    // R1: slot of core N at 0x40 + 0x10*N, bits [3:2] zero, core < count
    function automatic bit slot_hit(logic [7:0] a, int nc);
        return (a[3:2] == 2'b00) && (a[7:4] >= 4'd4) && ((int'(a[7:4]) - 4) < nc);
    endfunction

    function automatic logic get_rv(int i, int n);
        return (i == 0) ? rv4[n] : rv2[n];
    endfunction

    function automatic logic [31:0] get_rt(int i, int n);
        return (i == 0) ? rt4[n*32 +: 32] : rt2[n*32 +: 32];
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            for (int k = 0; k < 64; k++) mem[i][k] = '0;
            for (int n = 0; n < 4; n++) parked[i][n] = (n >= 1) && (n < nc_of(i));
        end
    endtask

    // R2: reset clears storage and outputs
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr = 1'b0;
        rd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        chk(rv4 == 4'b0, "R2 rel_valid4 after reset", 32'(rv4), 32'h0);
        chk(rv2 == 2'b0, "R2 rel_valid2 after reset", 32'(rv2), 32'h0);
        chk(!wake4 && !wake2, "R2 wake after reset", 32'({wake4, wake2}), 32'h0);
    endtask

    task automatic do_wr(logic [7:0] a, logic [31:0] d, string req);
        bit hit [2];
        @(negedge clk);
        wr = 1'b1;
        addr = a;
        wdata = d;
        @(negedge clk);
        wr = 1'b0;
        for (int i = 0; i < 2; i++) begin
            mem[i][a[7:2]] = d;
            hit[i] = slot_hit(a, nc_of(i));
        end
        chk(wake4 == hit[0], {req, " R3 wake4"}, 32'(wake4), 32'(hit[0]));
        chk(wake2 == hit[1], {req, " R3 wake2"}, 32'(wake2), 32'(hit[1]));
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            for (int n = 0; n < nc_of(i); n++) begin
                bit exp_rel;
                logic [31:0] sv;
                sv = mem[i][16 + 4*n];
                exp_rel = hit[i] && parked[i][n] && (sv != '0);
                chk(get_rv(i, n) == exp_rel, {req, " R4/R5/R6/R7 rel_valid"},
                    32'(get_rv(i, n)), 32'(exp_rel));
                if (exp_rel) begin
                    chk(get_rt(i, n) == sv, {req, " R4 rel_target"}, get_rt(i, n), sv);
                    parked[i][n] = 1'b0;
                end
            end
        end
    endtask

    // R8: registered whole-word read
    task automatic do_rd(logic [7:0] a, string req);
        @(negedge clk);
        rd = 1'b1;
        addr = a;
        @(negedge clk);
        rd = 1'b0;
        chk(rdata4 == mem[0][a[7:2]], {req, " R8 rdata4"}, rdata4, mem[0][a[7:2]]);
        chk(rdata2 == mem[1][a[7:2]], {req, " R8 rdata2"}, rdata2, mem[1][a[7:2]]);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog all-R actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        do_reset();

        // R2: all slots read zero after reset
        for (int n = 0; n < 4; n++) do_rd(8'(8'h40 + 16*n), "R2 slot zero");

        // R5: zero in core 1 slot wakes but keeps it parked
        do_wr(8'h50, 32'h0, "R5 zero slot");
        // R4: nonzero releases core 1
        do_wr(8'h50, 32'h0000_1000, "R4 release core1");
        // R6: later write to released core does nothing
        do_wr(8'h50, 32'h0000_2000, "R6 second write");
        do_rd(8'h50, "R6 stored");
        // R7: core 0 slot stored, wakes, never releases
        do_wr(8'h40, 32'hCAFE_0000, "R7 core0");
        do_rd(8'h40, "R7 readback");
        // R3: non-slot offset inside the table stride: no wake
        do_wr(8'h44, 32'h1111_1111, "R3 off-slot");
        // R1/R3: core 3 slot, absent in two-core copy
        do_wr(8'h70, 32'h0000_3000, "R1 core3");
        // R1: core 2 slot
        do_wr(8'h60, 32'h0000_2200, "R1 core2");
        // R8: low byte-lane bits ignored
        do_rd(8'h73, "R8 lane bits");
        do_wr(8'h0F, 32'hA5A5_5A5A, "R8 low word");
        do_rd(8'h0C, "R8 low word read");

        // R6: after reset a core can be released again
        do_reset();
        do_wr(8'h50, 32'h0000_4000, "R6 rerelease core1");

        // Random phase with periodic resets
        for (int op = 0; op < 400; op++) begin
            logic [7:0]  a;
            logic [31:0] d;
            if (op % 60 == 59) do_reset();
            if ($urandom % 2 == 0) a = 8'(8'h40 + 16*($urandom % 4) + ($urandom % 4));
            else a = 8'($urandom);
            d = ($urandom % 3 == 0) ? 32'h0 : $urandom;
            if ($urandom % 3 == 0) do_rd(a, "R8 random");
            else do_wr(a, d, "R3 random");
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule